// File: doc/BRIEF.md
# Double-Buffered Laser Pixel Line Buffer

This block holds one-bit pixels for a scanning laser in a single simple dual-port memory that is split into two halves. A slow host delivers pixel bytes one command at a time. Each byte goes into the half that is not being shown, at a write pointer that steps forward by itself or can be placed with a set-address command. At the same time a playback sequencer walks the displayed half bit by bit and drives the laser on/off output.

The host asks for a swap when its half is complete. The request is held until the next playback restart pulse. At that point the top bit of the read address flips, so the displayed image never changes in the middle of a line. The memory read path has two registered stages: the read address is registered and the read data is registered. The laser output register adds a third stage, and the sequencer's bit position is delayed to match. A debug mode replaces the memory data with a pattern that toggles on every pixel. Everything runs on one clock.

Top module: `laser_line_buffer`

## Requirements
- R1: After reset, `laser_out` is 0, `fill_half` is 1 (the lower half, half 0, is displayed), `swap_pending` is 0, and the write pointer and both playback counters are 0.
- R2: A store command (`host_valid`=1, `host_set_addr`=0) writes `host_data` to word `wr_ptr` of the half given by `fill_half`. The pointer then advances by one, or goes to 0 if it was at `MAX_WORD`.
- R3: A set-address command (`host_valid`=1, `host_set_addr`=1) loads the pointer with `host_data` when that value is strictly below `MAX_WORD`, and with 0 otherwise. A value equal to `MAX_WORD` also gives 0.
- R4: `fill_half` is always the inverse of the displayed half. Host writes never change what is played from the displayed half.
- R5: Playback emits bit 0 (LSB) of a word first and bit DATA_W-1 last, then moves to the next word. After word `MAX_WORD` it wraps to word 0 of the same half.
- R6: Each clock with `play_en`=1 and `line_restart`=0 consumes one pixel. That pixel appears on `laser_out` after the third rising edge that follows. Clocks with `play_en`=0 hold the position.
- R7: `laser_out` is 1 only if, three clocks earlier, `play_en` was 1 and `line_restart` was 0. Otherwise it is 0.
- R8: A `swap_req` pulse sets `swap_pending`. The displayed half and `fill_half` change only at a `line_restart` clock.
- R9: A `line_restart` clock sets the position to word 0, bit 0. It emits no pixel. It flips the displayed half if `swap_pending` or `swap_req` is 1 in that clock, and it clears `swap_pending`.
- R10: With `dbg_mode`=1, `laser_out` shows bit 0 of the pixel's bit position instead of memory data, with the same latency. The first pixel after a restart is 0, and the output toggles on every pixel after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_valid | input | 1 | Host command strobe, one command per clock |
| host_set_addr | input | 1 | 1 = set-address command, 0 = store command |
| host_data | input | DATA_W | Pixel byte for a store, or the address for a set-address command |
| swap_req | input | 1 | Request to show the half just filled, at the next restart |
| play_en | input | 1 | Playback advance enable, one pixel per clock |
| line_restart | input | 1 | Playback restart pulse; the swap point |
| dbg_mode | input | 1 | Selects the toggling test pattern |
| laser_out | output | 1 | Registered laser on/off drive |
| fill_half | output | 1 | Half the host writes (inverse of the displayed half) |
| swap_pending | output | 1 | A swap is waiting for the next restart |

## Verification
The bound checker watches the following every cycle:
- the write pointer stays within range, and wraps or clears after a store or set-address at the limit;
- `fill_half` changes only in the clock after a restart;
- the pending flag is set by a request and cleared by a restart;
- `laser_out` is never high unless a playing, non-restart clock occurred three cycles earlier.

Only the directed scenarios can show the pixel content and order:
- LSB-first bit order and the wrap from the last word back to word 0;
- the exact placement of words after set-address commands;
- that filling the hidden half leaves playback unchanged;
- a mid-line swap taking effect only at the following restart;
- the debug toggle pattern.

// File: rtl/llb_pkg.sv
package llb_pkg;
  typedef enum logic {
    HOST_STORE   = 1'b0,
    HOST_SETADDR = 1'b1
  } host_cmd_e;

  localparam int unsigned RST_SYNC_STAGES = 2;
endpackage

// File: rtl/llb_rst_sync.sv
module llb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/llb_wr_ctrl.sv
module llb_wr_ctrl
  import llb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_AW  = 4,
  parameter int MAX_WORD = (1 << HALF_AW) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_set_addr,
  input  logic [DATA_W-1:0]  cmd_data,
  output logic               mem_we,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [HALF_AW-1:0] wr_ptr
);
  localparam logic [HALF_AW-1:0] PTR_LAST = HALF_AW'(MAX_WORD);
  localparam logic [31:0]        LIMIT    = 32'(MAX_WORD);

  logic [HALF_AW-1:0] ptr_q, ptr_d;
  host_cmd_e          kind;

  always_comb begin
    kind      = host_cmd_e'(cmd_set_addr);
    ptr_d     = ptr_q;
    mem_we    = 1'b0;
    mem_wdata = cmd_data;
    if (cmd_valid) begin
      if (kind == HOST_SETADDR) begin
        ptr_d = (32'(cmd_data) < LIMIT) ? HALF_AW'(cmd_data) : '0;
      end else begin
        mem_we = 1'b1;
        ptr_d  = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (cmd_valid) ptr_q <= ptr_d;
  end

  assign wr_ptr = ptr_q;
endmodule

// File: rtl/llb_play_ctrl.sv
module llb_play_ctrl #(
  parameter int DATA_W   = 8,
  parameter int HALF_AW  = 4,
  parameter int MAX_WORD = (1 << HALF_AW) - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      play_en,
  input  logic                      line_restart,
  input  logic                      swap_req,
  output logic                      disp_half,
  output logic                      swap_pending,
  output logic [HALF_AW-1:0]        row,
  output logic [$clog2(DATA_W)-1:0] col,
  output logic                      pix_vld
);
  localparam int               COL_W    = $clog2(DATA_W);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(DATA_W - 1);
  localparam logic [HALF_AW-1:0] ROW_LAST = HALF_AW'(MAX_WORD);

  logic [HALF_AW-1:0] row_q, row_d;
  logic [COL_W-1:0]   col_q, col_d;
  logic               half_q, half_d;
  logic               pend_q, pend_d;
  logic               step;

  always_comb begin
    row_d  = row_q;
    col_d  = col_q;
    half_d = half_q;
    pend_d = pend_q | swap_req;
    step   = play_en & ~line_restart;
    if (line_restart) begin
      row_d  = '0;
      col_d  = '0;
      half_d = (pend_q | swap_req) ? ~half_q : half_q;
      pend_d = 1'b0;
    end else if (step) begin
      if (col_q == COL_LAST) begin
        col_d = '0;
        row_d = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      half_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (step | line_restart) begin
        row_q <= row_d;
        col_q <= col_d;
      end
      if (line_restart) half_q <= half_d;
      pend_q <= pend_d;
    end
  end

  assign disp_half    = half_q;
  assign swap_pending = pend_q;
  assign row          = row_q;
  assign col          = col_q;
  assign pix_vld      = step;
endmodule

// File: rtl/llb_dpram.sv
module llb_dpram #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] raddr_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raddr_q <= '0;
      rdata_q <= '0;
    end else begin
      raddr_q <= raddr;
      rdata_q <= mem_q[raddr_q];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/laser_line_buffer.sv
module laser_line_buffer
  import llb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_AW  = 4,
  parameter int MAX_WORD = (1 << HALF_AW) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_set_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              swap_req,
  input  logic              play_en,
  input  logic              line_restart,
  input  logic              dbg_mode,
  output logic              laser_out,
  output logic              fill_half,
  output logic              swap_pending
);
  localparam int MEM_AW = HALF_AW + 1;
  localparam int COL_W  = $clog2(DATA_W);

  logic               rst_sync_n;
  logic               mem_we;
  logic [DATA_W-1:0]  mem_wdata;
  logic [HALF_AW-1:0] wr_ptr;
  logic               disp_half;
  logic [HALF_AW-1:0] play_row;
  logic [COL_W-1:0]   play_col;
  logic               pix_vld;
  logic [DATA_W-1:0]  rd_word;
  logic [MEM_AW-1:0]  mem_waddr;
  logic [MEM_AW-1:0]  mem_raddr;

  logic [COL_W-1:0] col_d1_q, col_d2_q;
  logic             vld_d1_q, vld_d2_q;
  logic             laser_q, laser_d;

  llb_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  llb_wr_ctrl #(.DATA_W(DATA_W), .HALF_AW(HALF_AW), .MAX_WORD(MAX_WORD)) u_wr (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cmd_valid    (host_valid),
    .cmd_set_addr (host_set_addr),
    .cmd_data     (host_data),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .wr_ptr       (wr_ptr)
  );

  llb_play_ctrl #(.DATA_W(DATA_W), .HALF_AW(HALF_AW), .MAX_WORD(MAX_WORD)) u_play (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .play_en      (play_en),
    .line_restart (line_restart),
    .swap_req     (swap_req),
    .disp_half    (disp_half),
    .swap_pending (swap_pending),
    .row          (play_row),
    .col          (play_col),
    .pix_vld      (pix_vld)
  );

  assign fill_half = ~disp_half;
  assign mem_waddr = {fill_half, wr_ptr};
  assign mem_raddr = {disp_half, play_row};

  llb_dpram #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (rd_word)
  );

  // Bit position and valid follow the two memory stages.
  always_comb begin
    laser_d = vld_d2_q & (dbg_mode ? col_d2_q[0] : rd_word[col_d2_q]);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      col_d1_q <= '0;
      col_d2_q <= '0;
      vld_d1_q <= 1'b0;
      vld_d2_q <= 1'b0;
      laser_q  <= 1'b0;
    end else begin
      col_d1_q <= play_col;
      col_d2_q <= col_d1_q;
      vld_d1_q <= pix_vld;
      vld_d2_q <= vld_d1_q;
      laser_q  <= laser_d;
    end
  end

  assign laser_out = laser_q;
endmodule

// File: rtl/llb_checker.sv
module llb_checker #(
  parameter int DATA_W   = 8,
  parameter int HALF_AW  = 4,
  parameter int MAX_WORD = (1 << HALF_AW) - 1
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               host_valid,
  input logic               host_set_addr,
  input logic [DATA_W-1:0]  host_data,
  input logic               swap_req,
  input logic               play_en,
  input logic               line_restart,
  input logic               laser_out,
  input logic               fill_half,
  input logic               swap_pending,
  input logic [HALF_AW-1:0] wr_ptr,
  input logic [HALF_AW-1:0] play_row
);
  localparam logic [HALF_AW-1:0] LAST  = HALF_AW'(MAX_WORD);
  localparam logic [31:0]        LIMIT = 32'(MAX_WORD);

  // R2
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_ptr <= LAST);

  // R2
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_valid && !host_set_addr && wr_ptr == LAST) |=> (wr_ptr == '0));

  // R3
  setaddr_clip_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_valid && host_set_addr && (32'(host_data) >= LIMIT)) |=> (wr_ptr == '0));

  // R5
  row_in_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    play_row <= LAST);

  // R8
  half_only_at_restart_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(fill_half) |-> $past(line_restart));

  // R8
  pending_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (swap_req && !line_restart) |=> swap_pending);

  // R9
  pending_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    line_restart |=> !swap_pending);

  // R7
  laser_needs_play_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    laser_out |-> $past(play_en && !line_restart, 3));
endmodule

bind laser_line_buffer llb_checker #(
  .DATA_W(DATA_W), .HALF_AW(HALF_AW), .MAX_WORD(MAX_WORD)
) u_llb_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .host_valid    (host_valid),
  .host_set_addr (host_set_addr),
  .host_data     (host_data),
  .swap_req      (swap_req),
  .play_en       (play_en),
  .line_restart  (line_restart),
  .laser_out     (laser_out),
  .fill_half     (fill_half),
  .swap_pending  (swap_pending),
  .wr_ptr        (wr_ptr),
  .play_row      (play_row)
);

// File: tb/laser_line_buffer_bench.sv
`timescale 1ns/1ps
module laser_line_buffer_bench;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int WORDS = 1 << AW;
  localparam int MAXW  = WORDS - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0, host_set_addr = 1'b0;
  logic [DW-1:0] host_data = '0;
  logic swap_req = 1'b0, play_en = 1'b0, line_restart = 1'b0, dbg_mode = 1'b0;
  logic laser_out, fill_half, swap_pending;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_mem [2][WORDS];
  int exp_ptr = 0;
  logic exp_disp = 1'b0;
  logic exp_pend = 1'b0;
  int exp_row = 0;
  int exp_col = 0;

  always #10 clk = ~clk;

  laser_line_buffer #(.DATA_W(DW), .HALF_AW(AW), .MAX_WORD(MAXW)) u_laser_line_buffer (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_set_addr(host_set_addr),
    .host_data(host_data), .swap_req(swap_req), .play_en(play_en),
    .line_restart(line_restart), .dbg_mode(dbg_mode), .laser_out(laser_out),
    .fill_half(fill_half), .swap_pending(swap_pending)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Host command, one clock; updates the model per R2/R3/R4.
  task automatic host_cmd(input logic set, input logic [DW-1:0] d);
    host_valid = 1'b1; host_set_addr = set; host_data = d;
    @(negedge clk);
    host_valid = 1'b0; host_set_addr = 1'b0;
    if (set) exp_ptr = (int'(d) < MAXW) ? int'(d) : 0;
    else begin
      exp_mem[~exp_disp][exp_ptr] = d;
      exp_ptr = (exp_ptr == MAXW) ? 0 : exp_ptr + 1;
    end
  endtask

  task automatic pulse_swap();
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
    exp_pend = 1'b1;
  endtask

  // R9: restart, optional simultaneous swap request
  task automatic restart(input logic with_swap);
    line_restart = 1'b1; swap_req = with_swap;
    @(negedge clk);
    line_restart = 1'b0; swap_req = 1'b0;
    if (exp_pend || with_swap) exp_disp = ~exp_disp;
    exp_pend = 1'b0;
    exp_row = 0; exp_col = 0;
  endtask

  // R5/R6/R10: play n pixels, each visible 3 edges after its play clock
  task automatic play_check(input int n, input string req);
    for (int j = 1; j <= n + 2; j++) begin
      play_en = (j <= n);
      @(negedge clk);
      if (j >= 3) begin
        logic e;
        e = dbg_mode ? exp_col[0] : exp_mem[exp_disp][exp_row][exp_col];
        check(laser_out, e, req);
        exp_col++;
        if (exp_col == DW) begin
          exp_col = 0;
          exp_row = (exp_row == MAXW) ? 0 : exp_row + 1;
        end
      end
    end
    play_en = 1'b0;
    @(negedge clk);
    check(laser_out, 1'b0, "R7 idle after play");
  endtask

  task automatic t_reset();
    check(laser_out, 1'b0, "R1 laser");
    check(fill_half, 1'b1, "R1 fill_half");
    check(swap_pending, 1'b0, "R1 pending");
  endtask

  task automatic t_first_fill();
    for (int i = 0; i < WORDS; i++) host_cmd(1'b0, 8'(i * 37 + 5));
    pulse_swap();
    check(swap_pending, 1'b1, "R8 pending set");
    check(fill_half, 1'b1, "R8 no flip before restart");
    restart(1'b0);
    check(fill_half, 1'b0, "R9 flipped at restart");
    check(swap_pending, 1'b0, "R9 pending cleared");
    play_check(WORDS * DW + 2 * DW, "R5 order and wrap");
  endtask

  task automatic t_addr_cmds();
    for (int i = 0; i < WORDS + 1; i++) host_cmd(1'b0, 8'(i * 11 + 200));
    host_cmd(1'b1, 8'd9);   host_cmd(1'b0, 8'hD9);
    host_cmd(1'b1, 8'(MAXW)); host_cmd(1'b0, 8'hE0);
    host_cmd(1'b1, 8'(MAXW - 1)); host_cmd(1'b0, 8'h5E);
    host_cmd(1'b1, 8'd200); host_cmd(1'b0, 8'h81);
    restart(1'b0);
    check(fill_half, 1'b0, "R4 no swap without request");
    play_check(3 * DW, "R4 displayed half untouched");
    restart(1'b1);
    check(fill_half, 1'b1, "R9 simultaneous swap");
    play_check(WORDS * DW, "R2 R3 placement");
  endtask

  task automatic t_midline_swap();
    host_cmd(1'b1, 8'd0);
    for (int i = 0; i < WORDS; i++) host_cmd(1'b0, 8'(i * 73 + 1));
    restart(1'b0);
    play_check(20, "R6 first part");
    pulse_swap();
    check(fill_half, 1'b1, "R8 no flip mid-line");
    repeat (3) @(negedge clk);
    check(laser_out, 1'b0, "R7 paused");
    play_check(20, "R6 resume same half");
    restart(1'b0);
    check(fill_half, 1'b0, "R8 flip at restart");
    play_check(3 * DW, "R9 new half from word 0");
  endtask

  task automatic t_debug();
    dbg_mode = 1'b1;
    restart(1'b0);
    play_check(12, "R10 debug toggle");
    dbg_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_fill();
    t_addr_cmds();
    t_midline_swap();
    t_debug();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule